// File: doc/BRIEF.md
# Static Memory Bank Bus Controller

This block turns single-word requests from inside the chip into timed read and write cycles on an external asynchronous static memory bus. Up to four banks share the address and data lines. Each bank has its own active-low chip select and its own set of configuration registers. Those registers hold the data width (one or two bytes), a page-read enable, and six cycle counts that shape the bus cycle. In order, the counts cover address setup, select-to-strobe setup, access, strobe-to-deselect hold, address hold after deselect, and the in-page access time.

A request carries a bank index, an item offset, a read/write flag and write data. It is taken when `req_ready` is high, and `req_ready` stays low until the whole bus cycle, including address hold, has ended. Reads return one response per data item. A page read keeps the chip select low across four items at consecutive addresses and marks the fourth item as last. Writes always move one item, even on a bank with page reads enabled, and return one response. A request to a bank that does not exist gets an error response and causes no bus activity.

Configuration is written through a small port as one packed word per bank. The port only takes effect when the controller is idle and no request is being presented.

Top module: `smc_bank_ctrl`

## Requirements
- R1: After reset, every chip select, `mem_oen` and `mem_wen` are high, `mem_doe` and `rsp_valid` are low, and `req_ready` is high. Every bank's configuration is all zero, which means 1-byte width, no page mode and all counts 0.
- R2: At most one chip select is low at any time, and only the one for the bank of the request in progress. No chip select is low while `req_ready` is high.
- R3: `mem_oen` is low only while a chip select is low. `mem_oen` and `mem_wen` are never low together.
- R4: `mem_doe` is high only during a write, only while the chip select is low and `mem_oen` is high. While it is high, `mem_dout` carries the request's write data.
- R5: A single read keeps the address valid with the chip select high for Tasu cycles, then holds the chip select low for Tcsu+(Tacc+1)+Tcsh cycles. `mem_oen` is low for the middle Tacc+1 of those cycles. The address then stays held for Tahd cycles with the chip select high. A count of zero removes its phase.
- R6: On a read to a bank with page mode on, the chip select stays low across four items. `mem_oen` is low for (Tacc+1)+3*(Tpage+1) cycles. Items 2 to 4 each last Tpage+1 cycles, and `mem_addr` is offset+0 to offset+3 for items 1 to 4.
- R7: Width 0 (1 byte) returns read data with bits 15:8 zero and drives `mem_dout` bits 15:8 as zero. Width 1 (2 bytes) uses all 16 bits.
- R8: Read data is sampled from `mem_din` on the last cycle of the access or page-access phase. It appears one cycle later with `rsp_valid` high, `rsp_err` low, and `rsp_last` high only on the final item.
- R9: A write follows the same phase sequence with `mem_wen` low for Tacc+1 cycles in place of `mem_oen`. It moves one item even when page mode is on, and returns one response with `rsp_last` high and zero data.
- R10: A request whose bank index is not below NUM_BANKS is accepted and answered on the next cycle with `rsp_err` and `rsp_last` high and zero data. No chip select falls and `req_ready` stays high.
- R11: A configuration write is ignored unless the controller is idle and `req_valid` is low. A write issued mid-cycle leaves the bank's next cycle shaped by its previous settings.
- R12: `req_ready` goes low the cycle after acceptance and returns high only after the address-hold phase. A request presented back to back is accepted on the first idle cycle and gets its own complete phase sequence.

Configuration word layout on `cfg_wdata`: bit 0 width, bit 1 page enable, [5:2] Tasu, [9:6] Tcsu, [14:10] Tacc, [18:15] Tcsh, [22:19] Tahd, [26:23] Tpage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bank | input | SEL_W (2) | Bank whose configuration is written |
| cfg_wdata | input | 27 | Packed bank configuration word |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request is taken |
| req_bank | input | IDX_W (3) | Bank index of the request |
| req_offs | input | ADDR_W (16) | Item offset within the bank |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_err | output | 1 | Request named a missing bank |
| rsp_last | output | 1 | Final response of the request |
| rsp_rdata | output | 16 | Read data, zero for writes and errors |
| mem_addr | output | ADDR_W (16) | External address |
| mem_csn | output | NUM_BANKS (4) | Active-low chip selects, one per bank |
| mem_oen | output | 1 | Active-low output enable |
| mem_wen | output | 1 | Active-low write enable |
| mem_dout | output | 16 | Data driven toward the memory |
| mem_doe | output | 1 | Data bus drive enable |
| mem_din | input | 16 | Data returned by the memory |

## Verification
The bench targets several corner cases:

- **Zero counts.** With every count at zero, the whole cycle shrinks to a single access cycle. A design that reloaded a zero count as a full wrap would stretch the cycle by many cycles.
- **Maximum counts.** With all counts at their maximum (Tacc 31, the rest 15), the bench checks the counter width. An off-by-one in the access-plus-one rule shows up as a chip-select or strobe window one cycle long or short.
- **Page reads.** The bench checks that the address steps through four items under one chip select and that only the fourth item carries `rsp_last`. It also checks that a page-enabled write still moves a single item.
- **Other ports and modes.** The bench covers out-of-range bank indices, which must not produce a bus cycle. It also covers a configuration write that lands mid-cycle and must leave the next cycle unchanged, and back-to-back requests, which must not merge their hold and setup phases.

// File: rtl/smc_pkg.sv
package smc_pkg;

   localparam int DATA_W    = 16;
   localparam int BYTE_W    = 8;
   localparam int PAGE_ITEMS = 4;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ASU,
      PH_CSU,
      PH_ACC,
      PH_PAGE,
      PH_CSH,
      PH_AHD
   } phase_e;

   // packed configuration word, bit 0 is the width flag
   typedef struct packed {
      logic [3:0] t_page;
      logic [3:0] t_ahd;
      logic [3:0] t_csh;
      logic [4:0] t_acc;
      logic [3:0] t_csu;
      logic [3:0] t_asu;
      logic       page_en;
      logic       wide;
   } bank_cfg_t;

   localparam int CFG_W = $bits(bank_cfg_t);

endpackage

// File: rtl/smc_cfg_regs.sv
module smc_cfg_regs
   import smc_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int SEL_W     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_bank,
   input  bank_cfg_t        wr_data,
   input  logic [SEL_W-1:0] rd_bank,
   output bank_cfg_t        rd_cfg
);

   bank_cfg_t cfg_arr [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cfg_arr[b] <= '0;
         else if (wr_en && wr_bank == SEL_W'(b))
            cfg_arr[b] <= wr_data;
      end
   end

   always_comb begin
      rd_cfg = '0;
      for (int b = 0; b < NUM_BANKS; b++)
         if (rd_bank == SEL_W'(b))
            rd_cfg = cfg_arr[b];
   end

endmodule

// File: rtl/smc_phase_seq.sv
module smc_phase_seq
   import smc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       is_write,
   input  bank_cfg_t  cfg,
   output phase_e     phase,
   output logic [1:0] beat,
   output logic       beat_end
);

   phase_e     ph_q, ph_d;
   logic [4:0] cnt_q;
   logic [1:0] beat_q;
   logic       last, advance, more;

   // drop phases whose programmed count is zero
   function automatic phase_e skip_empty(input phase_e p, input bank_cfg_t c);
      phase_e r;
      r = p;
      if (r == PH_ASU && c.t_asu == 4'd0) r = PH_CSU;
      if (r == PH_CSU && c.t_csu == 4'd0) r = PH_ACC;
      if (r == PH_CSH && c.t_csh == 4'd0) r = PH_AHD;
      if (r == PH_AHD && c.t_ahd == 4'd0) r = PH_IDLE;
      return r;
   endfunction

   // cycles in a phase, minus one
   function automatic logic [4:0] span_m1(input phase_e p, input bank_cfg_t c);
      case (p)
         PH_ASU:  span_m1 = {1'b0, c.t_asu} - 5'd1;
         PH_CSU:  span_m1 = {1'b0, c.t_csu} - 5'd1;
         PH_ACC:  span_m1 = c.t_acc;
         PH_PAGE: span_m1 = {1'b0, c.t_page};
         PH_CSH:  span_m1 = {1'b0, c.t_csh} - 5'd1;
         PH_AHD:  span_m1 = {1'b0, c.t_ahd} - 5'd1;
         default: span_m1 = '0;
      endcase
   endfunction

   always_comb begin
      last     = (cnt_q == 5'd0);
      beat_end = (ph_q == PH_ACC || ph_q == PH_PAGE) && last;
      more     = cfg.page_en && !is_write && (beat_q != 2'(PAGE_ITEMS - 1));
      advance  = (ph_q == PH_IDLE) ? start : last;
      ph_d     = ph_q;
      if (advance) begin
         case (ph_q)
            PH_IDLE:         ph_d = skip_empty(PH_ASU, cfg);
            PH_ASU:          ph_d = skip_empty(PH_CSU, cfg);
            PH_CSU:          ph_d = PH_ACC;
            PH_ACC, PH_PAGE: ph_d = more ? PH_PAGE : skip_empty(PH_CSH, cfg);
            PH_CSH:          ph_d = skip_empty(PH_AHD, cfg);
            default:         ph_d = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         cnt_q  <= '0;
         beat_q <= '0;
      end else begin
         ph_q <= ph_d;
         if (advance)
            cnt_q <= span_m1(ph_d, cfg);
         else if (ph_q != PH_IDLE)
            cnt_q <= cnt_q - 5'd1;
         if (ph_q == PH_IDLE && start)
            beat_q <= '0;
         else if (beat_end && ph_d == PH_PAGE)
            beat_q <= beat_q + 2'd1;
      end
   end

   assign phase = ph_q;
   assign beat  = beat_q;

endmodule

// File: rtl/smc_bank_ctrl.sv
module smc_bank_ctrl
   import smc_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ADDR_W    = 16,
   parameter int IDX_W     = 3,
   localparam int SEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_bank,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [IDX_W-1:0]  req_bank,
   input  logic [ADDR_W-1:0] req_offs,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic              rsp_last,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [NUM_BANKS-1:0] mem_csn,
   output logic              mem_oen,
   output logic              mem_wen,
   output logic [DATA_W-1:0] mem_dout,
   output logic              mem_doe,
   input  logic [DATA_W-1:0] mem_din
);

   if (NUM_BANKS < 1 || NUM_BANKS > 4) begin : g_bad_banks
      $error("NUM_BANKS must be 1 to 4");
   end
   if (IDX_W < SEL_W || IDX_W > 30) begin : g_bad_idx
      $error("IDX_W must cover the bank select and stay below 31");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must be at least 2");
   end

   phase_e            phase;
   logic [1:0]        beat;
   logic              beat_end, idle, accept, in_range, start, cs_act;
   bank_cfg_t         cfg_cur;
   logic [SEL_W-1:0]  bank_q, rd_bank;
   logic [ADDR_W-1:0] offs_q;
   logic              wr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              rsp_valid_q, rsp_err_q, rsp_last_q;
   logic [DATA_W-1:0] rdata_q;

   function automatic logic [DATA_W-1:0] fit_width(input logic [DATA_W-1:0] d,
                                                   input logic wide);
      return wide ? d : {{(DATA_W-BYTE_W){1'b0}}, d[BYTE_W-1:0]};
   endfunction

   assign idle      = (phase == PH_IDLE);
   assign req_ready = idle;
   assign accept    = req_valid && idle;
   assign in_range  = ({{(32-IDX_W){1'b0}}, req_bank} < 32'(NUM_BANKS));
   assign start     = accept && in_range;
   assign rd_bank   = idle ? req_bank[SEL_W-1:0] : bank_q;

   smc_cfg_regs #(.NUM_BANKS(NUM_BANKS), .SEL_W(SEL_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we && idle && !req_valid),
      .wr_bank (cfg_bank),
      .wr_data (bank_cfg_t'(cfg_wdata)),
      .rd_bank (rd_bank),
      .rd_cfg  (cfg_cur)
   );

   smc_phase_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .is_write (wr_q),
      .cfg      (cfg_cur),
      .phase    (phase),
      .beat     (beat),
      .beat_end (beat_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q      <= '0;
         offs_q      <= '0;
         wr_q        <= 1'b0;
         wdata_q     <= '0;
         rsp_valid_q <= 1'b0;
         rsp_err_q   <= 1'b0;
         rsp_last_q  <= 1'b0;
         rdata_q     <= '0;
      end else begin
         if (start) begin
            bank_q  <= req_bank[SEL_W-1:0];
            offs_q  <= req_offs;
            wr_q    <= req_write;
            wdata_q <= req_wdata;
         end
         rsp_valid_q <= (accept && !in_range) || beat_end;
         rsp_err_q   <= accept && !in_range;
         rsp_last_q  <= (accept && !in_range) ||
                        (beat_end && (wr_q || !cfg_cur.page_en || beat == 2'(PAGE_ITEMS - 1)));
         rdata_q     <= (beat_end && !wr_q) ? fit_width(mem_din, cfg_cur.wide) : '0;
      end
   end

   assign rsp_valid = rsp_valid_q;
   assign rsp_err   = rsp_err_q;
   assign rsp_last  = rsp_last_q;
   assign rsp_rdata = rdata_q;

   assign cs_act   = (phase == PH_CSU) || (phase == PH_ACC) ||
                     (phase == PH_PAGE) || (phase == PH_CSH);
   assign mem_addr = offs_q + ADDR_W'(beat);
   assign mem_oen  = !(!wr_q && (phase == PH_ACC || phase == PH_PAGE));
   assign mem_wen  = !(wr_q && phase == PH_ACC);
   assign mem_doe  = wr_q && cs_act;
   assign mem_dout = fit_width(wdata_q, cfg_cur.wide);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_csn
      assign mem_csn[b] = !(cs_act && bank_q == SEL_W'(b));
   end

endmodule

// File: rtl/smc_bank_ctrl_chk.sv
module smc_bank_ctrl_chk #(
   parameter int NUM_BANKS = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_BANKS-1:0] mem_csn,
   input logic                 mem_oen,
   input logic                 mem_wen,
   input logic                 mem_doe,
   input logic                 rsp_valid,
   input logic                 rsp_err,
   input logic                 req_ready
);

   // R2: never two chip selects at once
   a_r2_single_select: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~mem_csn));

   // R2: chip selects stay high while the controller reports idle
   a_r2_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (&mem_csn));

   // R3: output enable only inside a chip-select window
   a_r3_oe_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oen |-> !(&mem_csn));

   // R3: the two strobes are exclusive
   a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oen && !mem_wen));

   // R4: data bus driven only inside a selected, non-read window
   a_r4_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
      mem_doe |-> (!(&mem_csn) && mem_oen));

   // R10: an error answer comes with no bus activity and an idle controller
   a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> ((&mem_csn) && req_ready));

endmodule

bind smc_bank_ctrl smc_bank_ctrl_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_csn   (mem_csn),
   .mem_oen   (mem_oen),
   .mem_wen   (mem_wen),
   .mem_doe   (mem_doe),
   .rsp_valid (rsp_valid),
   .rsp_err   (rsp_err),
   .req_ready (req_ready)
);

// File: tb/smc_bank_ctrl_tb.sv
module smc_bank_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_bank = '0;
   logic [26:0] cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [2:0]  req_bank = '0;
   logic [15:0] req_offs = '0;
   logic        req_write = 1'b0;
   logic [15:0] req_wdata = '0;
   logic        rsp_valid, rsp_err, rsp_last;
   logic [15:0] rsp_rdata, mem_addr, mem_dout, mem_din;
   logic [3:0]  mem_csn;
   logic        mem_oen, mem_wen, mem_doe;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;
   bit mon_on = 1'b0;

   always #4 clk = ~clk;

   smc_bank_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
      .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
      .req_bank(req_bank), .req_offs(req_offs), .req_write(req_write),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
      .rsp_last(rsp_last), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
      .mem_csn(mem_csn), .mem_oen(mem_oen), .mem_wen(mem_wen),
      .mem_dout(mem_dout), .mem_doe(mem_doe), .mem_din(mem_din)
   );

   function automatic logic [15:0] mdata(input logic [15:0] a);
      return (a * 16'h0101) ^ 16'h5A3C;
   endfunction

   // memory answers only while its output is enabled
   assign mem_din = mem_oen ? 16'hDEAD : mdata(mem_addr);

   typedef struct {
      logic        err;
      logic        last;
      logic [15:0] data;
      string       tag;
   } rsp_t;

   typedef struct {
      int          pre, cs, oe, we, post, doe;
      logic [15:0] dout;
      string       tag;
   } shape_t;

   rsp_t   rsp_q[$];
   shape_t shape_q[$];

   // bench model of bank configuration
   int m_wide[4], m_page[4], m_asu[4], m_csu[4], m_acc[4], m_csh[4], m_ahd[4], m_pg[4];

   task automatic chk(input bit ok, input string tag, input string what,
                      input string act, input string exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%s expected=%s", tag, what, act, exp);
      end
   endtask

   task automatic cfg_write(input int b, input int wide, input int page, input int asu,
                            input int csu, input int acc, input int csh, input int ahd,
                            input int pg, input bit model_takes);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_bank  = 2'(b);
      cfg_wdata = {4'(pg), 4'(ahd), 4'(csh), 5'(acc), 4'(csu), 4'(asu), 1'(page), 1'(wide)};
      @(negedge clk);
      cfg_we = 1'b0;
      if (model_takes) begin
         m_wide[b] = wide; m_page[b] = page; m_asu[b] = asu; m_csu[b] = csu;
         m_acc[b] = acc; m_csh[b] = csh; m_ahd[b] = ahd; m_pg[b] = pg;
      end
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (!req_ready || rsp_q.size() != 0 || shape_q.size() != 0) @(negedge clk);
   endtask

   task automatic do_req(input int b, input int offs, input bit wr,
                         input logic [15:0] wd, input string tag);
      if (b >= 4) begin
         rsp_q.push_back('{1'b1, 1'b1, 16'h0, tag});
      end else begin
         shape_t s;
         int items;
         items  = (m_page[b] != 0 && !wr) ? 4 : 1;
         s.pre  = m_asu[b];
         s.oe   = wr ? 0 : (m_acc[b] + 1) + (items - 1) * (m_pg[b] + 1);
         s.we   = wr ? m_acc[b] + 1 : 0;
         s.cs   = m_csu[b] + (m_acc[b] + 1) + (items - 1) * (m_pg[b] + 1) + m_csh[b];
         s.post = m_ahd[b];
         s.doe  = wr ? s.cs : 0;
         s.dout = m_wide[b] != 0 ? wd : {8'h00, wd[7:0]};
         s.tag  = tag;
         shape_q.push_back(s);
         for (int i = 0; i < items; i++) begin
            logic [15:0] d;
            d = wr ? 16'h0 : mdata(16'(offs + i));
            if (m_wide[b] == 0) d[15:8] = 8'h00;
            rsp_q.push_back('{1'b0, i == items - 1, d, tag});
         end
      end
      @(negedge clk);
      req_valid = 1'b1;
      req_bank  = 3'(b);
      req_offs  = 16'(offs);
      req_write = wr;
      req_wdata = wd;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // monitor: responses and bus shape
   int c_pre, c_cs, c_oe, c_we, c_post, c_doe;
   bit seen_cs, was_busy, dout_bad;

   always @(negedge clk) begin
      if (mon_on) begin
         if (rsp_valid) begin
            if (rsp_q.size() == 0) begin
               chk(1'b0, "R8", "unexpected response", $sformatf("%h", rsp_rdata), "none");
            end else begin
               rsp_t e;
               e = rsp_q.pop_front();
               chk(rsp_err == e.err && rsp_last == e.last && rsp_rdata == e.data, e.tag,
                   "response err/last/data",
                   $sformatf("%b/%b/%h", rsp_err, rsp_last, rsp_rdata),
                   $sformatf("%b/%b/%h", e.err, e.last, e.data));
            end
         end
         if (!req_ready) begin
            was_busy = 1'b1;
            if (&mem_csn) begin
               if (seen_cs) c_post++; else c_pre++;
            end else begin
               seen_cs = 1'b1;
               c_cs++;
            end
            if (!mem_oen) c_oe++;
            if (!mem_wen) c_we++;
            if (mem_doe) begin
               c_doe++;
               if (shape_q.size() == 0 || mem_dout != shape_q[0].dout) dout_bad = 1'b1;
            end
         end else begin
            if (!(&mem_csn) || mem_doe)
               chk(1'b0, "R2", "bus active while idle", $sformatf("%b", mem_csn), "1111");
            if (was_busy) begin
               if (shape_q.size() == 0) begin
                  chk(1'b0, "R10", "bus cycle with none expected", "cycle", "none");
               end else begin
                  shape_t s;
                  s = shape_q.pop_front();
                  chk(c_pre == s.pre && c_cs == s.cs && c_oe == s.oe && c_we == s.we &&
                      c_post == s.post && c_doe == s.doe && !dout_bad, s.tag,
                      "pre/cs/oe/we/post/doe/dout_ok",
                      $sformatf("%0d/%0d/%0d/%0d/%0d/%0d/%0d", c_pre, c_cs, c_oe, c_we,
                                c_post, c_doe, !dout_bad),
                      $sformatf("%0d/%0d/%0d/%0d/%0d/%0d/1", s.pre, s.cs, s.oe, s.we,
                                s.post, s.doe));
               end
            end
            was_busy = 1'b0; seen_cs = 1'b0; dout_bad = 1'b0;
            c_pre = 0; c_cs = 0; c_oe = 0; c_we = 0; c_post = 0; c_doe = 0;
         end
      end
   end

   initial begin
      for (int b = 0; b < 4; b++) begin
         m_wide[b] = 0; m_page[b] = 0; m_asu[b] = 0; m_csu[b] = 0;
         m_acc[b] = 0; m_csh[b] = 0; m_ahd[b] = 0; m_pg[b] = 0;
      end
      repeat (3) @(negedge clk);
      // R1: quiet outputs in reset
      chk(mem_csn == 4'hF && mem_oen && mem_wen && !mem_doe && !rsp_valid && req_ready,
          "R1", "reset outputs csn/oen/wen/doe/rsp/ready",
          $sformatf("%b/%b/%b/%b/%b/%b", mem_csn, mem_oen, mem_wen, mem_doe, rsp_valid, req_ready),
          "1111/1/1/0/0/1");
      rst_n = 1'b1;
      @(negedge clk);
      mon_on = 1'b1;

      // R1 R5 R7: reset configuration gives a one-cycle byte read
      do_req(0, 16'h0010, 1'b0, 16'h0, "R1");
      wait_idle();

      // R5 R8: full single read with every phase present
      cfg_write(1, 1, 0, 2, 1, 3, 2, 1, 0, 1'b1);
      do_req(1, 16'h0123, 1'b0, 16'h0, "R5");
      wait_idle();
      // R9 R4: write on a two-byte bank
      do_req(1, 16'h0040, 1'b1, 16'hBEEF, "R9");
      wait_idle();

      // R6 R7: page read on a byte bank
      cfg_write(2, 0, 1, 1, 1, 2, 1, 2, 1, 1'b1);
      do_req(2, 16'h0200, 1'b0, 16'h0, "R6");
      wait_idle();
      // R9: page-enabled write still moves one item, byte lane only (R7)
      do_req(2, 16'h0201, 1'b1, 16'hCAFE, "R9");
      wait_idle();

      // R10: missing banks
      do_req(5, 16'h0001, 1'b0, 16'h0, "R10");
      do_req(4, 16'h0002, 1'b1, 16'h1111, "R10");
      wait_idle();

      // R5 R6: maximum counts with page reads on a wide bank
      cfg_write(3, 1, 1, 15, 15, 31, 15, 15, 15, 1'b1);
      do_req(3, 16'hFFFE, 1'b0, 16'h0, "R6");
      wait_idle();
      do_req(3, 16'h0300, 1'b1, 16'h8421, "R9");
      wait_idle();

      // R11: configuration write during a cycle is dropped
      cfg_write(0, 1, 0, 3, 0, 0, 0, 0, 0, 1'b1);
      do_req(0, 16'h0050, 1'b0, 16'h0, "R11");
      cfg_write(0, 0, 1, 9, 4, 7, 4, 4, 2, 1'b0);
      wait_idle();
      do_req(0, 16'h0051, 1'b0, 16'h0, "R11");
      wait_idle();

      // R12: back-to-back requests keep separate phase sequences
      do_req(1, 16'h0700, 1'b0, 16'h0, "R12");
      do_req(3, 16'h0800, 1'b1, 16'h5AA5, "R12");
      do_req(1, 16'h0701, 1'b1, 16'h1234, "R12");
      wait_idle();
      repeat (4) @(negedge clk);

      chk(rsp_q.size() == 0 && shape_q.size() == 0, "R12", "pending expectations",
          $sformatf("%0d/%0d", rsp_q.size(), shape_q.size()), "0/0");
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL R12 watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule